// File: doc/BRIEF.md
# Frame-Synchronous Scanout Address Bank

This block holds the base addresses that a second display pipe's fetch engine uses to read a frame from memory: for example the two field bases and the chroma plane bases. Each address exists twice. Software writes reach a pending (shadow) copy at any time. The copy the fetch engine sees (the live copy) changes only when vertical blank begins. A frame that is being scanned out therefore keeps one consistent set of addresses from its first line to its last. Anything programmed during that frame shows up in the next one, so no frame ever mixes old and new bases.

Addresses must fall on 64-byte (8-quadword) units. The bank keeps only the upper bits of each address. The six least significant bits are dropped on write and are always presented as zero. When the vertical-blank flag from the timing generator rises, all live registers load from their shadow copies in the same clock cycle. A readback port returns either copy of any register, chosen by a select input.

Top module: `frame_addr_bank`

## Requirements
- R1: After reset, every shadow copy and every live copy reads as zero on both the readback port and the live-address outputs.
- R2: When bit i of `wr_en` is 1 at a clock edge, shadow register i takes `wr_data` with bits [5:0] cleared. Readback of that shadow copy shows the new value from the next cycle on.
- R3: The live outputs stay unchanged in every cycle without a rising edge of `vblank`, whatever writes occur.
- R4: At a clock edge where `vblank` is 1 and was 0 at the previous edge, all live registers load their shadow values together. The new values appear on `live_addr` in the following cycle.
- R5: Holding `vblank` high, or a falling edge of `vblank`, causes no reload.
- R6: A write in the same cycle as the reload edge updates the shadow copy only. The live copy takes the previous shadow value, and the new value becomes live at the next rising edge of `vblank`.
- R7: Each `wr_en` bit affects only its own register. Several bits set together write the same data to each selected register.
- R8: `rd_data` shows shadow register `rd_sel` when `rd_live` is 0, and live register `rd_sel` when `rd_live` is 1. The readback path is combinational.
- R9: Bits [5:0] of every live address and of every readback value are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NUM_REGS | Per-register write enable into the shadow copies |
| wr_data | input | ADDR_W | Address to write; low ALIGN_LSB bits ignored |
| rd_sel | input | SEL_W | Register index for readback |
| rd_live | input | 1 | 0 selects the shadow copy, 1 the live copy, for readback |
| rd_data | output | ADDR_W | Readback value |
| vblank | input | 1 | Vertical-blank flag from the timing generator |
| live_addr | output | NUM_REGS*ADDR_W | Live addresses; register i at bits [i*ADDR_W +: ADDR_W] |

## Verification
A shadow register that is corrupted or written by the wrong enable is visible on readback in the cycle after the write. It reaches `live_addr` one cycle after the next rising edge of `vblank`. A fault in edge detection is different: a missed reload, a reload on level, or a reload on every cycle shows on `live_addr` in the very next cycle, because every live slice is compared each cycle. A write ordered wrongly against a coinciding reload leaves the live copy one frame early or late. The directed coincident-edge case isolates that fault.

// File: rtl/frame_addr_bank.sv
module frame_addr_bank #(
  parameter int NUM_REGS  = 4,
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 6,
  localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REGS-1:0]        wr_en,
  input  logic [ADDR_W-1:0]          wr_data,
  input  logic [SEL_W-1:0]           rd_sel,
  input  logic                       rd_live,
  output logic [ADDR_W-1:0]          rd_data,
  input  logic                       vblank,
  output logic [NUM_REGS*ADDR_W-1:0] live_addr
);
  localparam int HI_W = ADDR_W - ALIGN_LSB;

  logic [HI_W-1:0] shadow_q [NUM_REGS];
  logic [HI_W-1:0] live_q   [NUM_REGS];
  logic [NUM_REGS*ADDR_W-1:0] shadow_flat;
  logic vblank_q;
  logic reload;

  assign reload = vblank & ~vblank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vblank_q <= 1'b0;
    else        vblank_q <= vblank;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[i] <= '0;
        live_q[i]   <= '0;
      end else begin
        if (wr_en[i]) shadow_q[i] <= wr_data[ADDR_W-1:ALIGN_LSB];
        if (reload)   live_q[i]   <= shadow_q[i];
      end
    end
    assign live_addr[i*ADDR_W +: ADDR_W]   = {live_q[i],   {ALIGN_LSB{1'b0}}};
    assign shadow_flat[i*ADDR_W +: ADDR_W] = {shadow_q[i], {ALIGN_LSB{1'b0}}};
  end

  assign rd_data = rd_live ? live_addr[rd_sel*ADDR_W +: ADDR_W]
                           : shadow_flat[rd_sel*ADDR_W +: ADDR_W];
endmodule

// File: rtl/frame_addr_bank_chk.sv
module frame_addr_bank_chk #(
  parameter int NUM_REGS  = 4,
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_REGS-1:0]        wr_en,
  input logic [ADDR_W-1:0]          wr_data,
  input logic                       vblank,
  input logic [ADDR_W-1:0]          rd_data,
  input logic [NUM_REGS*ADDR_W-1:0] live_addr,
  input logic [NUM_REGS*ADDR_W-1:0] shadow_flat
);
  logic vb_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) vb_seen <= 1'b0;
    else        vb_seen <= vblank;
  end

  assert_hold_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank && !vb_seen) |=> $stable(live_addr));

  assert_reload_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !vb_seen) |=> live_addr == $past(shadow_flat));

  assert_readback_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ALIGN_LSB-1:0] == '0);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    assert_shadow_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> shadow_flat[i*ADDR_W+ALIGN_LSB +: ADDR_W-ALIGN_LSB]
                   == $past(wr_data[ADDR_W-1:ALIGN_LSB]));
    assert_shadow_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[i] |=> $stable(shadow_flat[i*ADDR_W +: ADDR_W]));
    assert_live_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      live_addr[i*ADDR_W +: ALIGN_LSB] == '0);
  end
endmodule

bind frame_addr_bank frame_addr_bank_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .vblank(vblank), .rd_data(rd_data), .live_addr(live_addr),
  .shadow_flat(shadow_flat)
);

// File: tb/tb_frame_addr_bank.sv
module tb_frame_addr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] wr_en = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic rd_live = 1'b0;
  logic [W-1:0] rd_data;
  logic vblank = 1'b0;
  logic [N*W-1:0] live_addr;

  frame_addr_bank #(.NUM_REGS(N), .ADDR_W(W), .ALIGN_LSB(6)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_live(rd_live), .rd_data(rd_data),
    .vblank(vblank), .live_addr(live_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [W-1:0] m_shadow [N];
  logic [W-1:0] m_live [N];
  logic m_vb;

  function automatic logic [W-1:0] align(input logic [W-1:0] x);
    return x & ~32'h3F;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) check(req, live_addr[i*W +: W], m_live[i]);
    check(req, rd_data, rd_live ? m_live[rd_sel] : m_shadow[rd_sel]);
  endtask

  task automatic step(input logic [N-1:0] we, input logic [W-1:0] d,
                      input logic vb, input logic [1:0] sel, input logic lv);
    @(negedge clk);
    wr_en = we; wr_data = d; vblank = vb; rd_sel = sel; rd_live = lv;
    @(posedge clk);
    if (vb && !m_vb) for (int i = 0; i < N; i++) m_live[i] = m_shadow[i];
    for (int i = 0; i < N; i++) if (we[i]) m_shadow[i] = align(d);
    m_vb = vb;
    #1;
  endtask

  task automatic peek(input logic [1:0] sel, input logic lv, input string req);
    @(negedge clk);
    rd_sel = sel; rd_live = lv;
    #1;
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_shadow[i] = '0; m_live[i] = '0; end
    m_vb = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int s = 0; s < N; s++) begin
      peek(2'(s), 1'b0, "R1");
      peek(2'(s), 1'b1, "R1");
    end

    step(4'b0001, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0);
    check("R2", rd_data, 32'hFFFF_FFC0);
    check("R9", {26'd0, rd_data[5:0]}, 32'd0);
    check("R3", live_addr[W-1:0], 32'd0);

    step(4'b0110, 32'h1234_567F, 1'b0, 2'd0, 1'b0);
    check("R7", rd_data, 32'hFFFF_FFC0);
    peek(2'd2, 1'b0, "R7");
    check("R7", rd_data, 32'h1234_5640);
    peek(2'd3, 1'b0, "R7");
    check("R7", rd_data, 32'h0);

    step(4'b0000, 32'h0, 1'b1, 2'd1, 1'b1);
    check_all("R4");
    check("R8", rd_data, 32'h1234_5640);
    check("R4", live_addr[W-1:0], 32'hFFFF_FFC0);

    step(4'b0010, 32'hAAAA_AAAA, 1'b1, 2'd1, 1'b1);
    step(4'b0000, 32'h0, 1'b1, 2'd1, 1'b1);
    check("R5", rd_data, 32'h1234_5640);
    step(4'b0000, 32'h0, 1'b0, 2'd1, 1'b0);
    check("R5", live_addr[W +: W], 32'h1234_5640);
    check("R8", rd_data, 32'hAAAA_AA80);

    step(4'b0100, 32'h0BAD_F00D, 1'b1, 2'd2, 1'b0);
    check("R6", rd_data, 32'h0BAD_F000);
    check("R6", live_addr[2*W +: W], 32'h1234_5640);
    check("R6", live_addr[W +: W], 32'hAAAA_AA80);
    step(4'b0000, 32'h0, 1'b0, 2'd2, 1'b1);
    step(4'b0000, 32'h0, 1'b1, 2'd2, 1'b1);
    check("R6", rd_data, 32'h0BAD_F000);

    for (int f = 0; f < 60; f++) begin
      int active = 8 + ($urandom % 20);
      int blank = 1 + ($urandom % 4);
      for (int c = 0; c < active + blank; c++) begin
        logic [N-1:0] we = (($urandom % 3) == 0) ? 4'($urandom) : '0;
        step(we, $urandom, (c >= active), 2'($urandom), 1'($urandom));
        check_all("R3/R4/R8");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule